// File: doc/BRIEF.md
# Read-Only Telemetry Register Slave on a Two-Wire Bus

This block is a two-wire (I2C) target that lets a host read a bank of 32-bit telemetry words. The host first writes a 16-bit byte offset, high byte first. It then reads, after a repeated START or after a new START, and gets bytes from that offset onward. Each word is sent least-significant byte first. The byte offset advances by one for every byte the block loads for transmission, so a long read runs on into the words that follow.

The register contents belong to internal logic. The block presents a word index on a combinational read port and takes back the word together with a presence flag. A word whose presence flag is low reads as a fixed marker. The link-status word has its upper bits forced to zero. Offsets outside the telemetry window read as zero. Data bytes that the host writes after the offset are acknowledged and have no effect.

The block drives only the open-drain data line. It never stretches the clock and does not arbitrate.

Top module: `i2ct_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 7'h5E (0xBC to write, 0xBD to read). For any other address it leaves SDA released through the ACK slot and every following byte until the next START.
- R2: In a write transfer, the first data byte sets offset bits [15:8] and the second data byte sets offset bits [7:0]. Both bytes are acknowledged.
- R3: Write data bytes after the second are acknowledged and discarded, and the offset keeps the value set by R2.
- R4: Inside the window, the read byte at offset o is bits [8*(o mod 4)+7 : 8*(o mod 4)] of word (o-0x100)/4, so each word goes out least-significant byte first.
- R5: Each transmitted byte advances the offset by one, so a read crosses from one word into the next.
- R6: Offsets below 0x100 or above 0x177 read as 0x00. The read port index always stays below the word count.
- R7: Word 25 (offsets 0x164 to 0x167) returns only its bits [7:0]; bits [31:8] read as zero.
- R8: A word whose presence flag is low reads as 0xDEADBEEF, sent as EF, BE, AD, DE.
- R9: A host NACK ends the read. SDA is released in the host's ACK slot and stays released while the block is idle.
- R10: After reset the offset is 0x0000, so a read with no offset set returns 0x00, and SDA is released.
- R11: A repeated START after the offset write, with no STOP between, keeps the offset.
- R12: The block changes SDA only while SCL is low: one synchronized SCL fall, or a START or STOP, comes before every change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| rd_index | output | 5 | Word index presented to the register file |
| rd_word | input | 32 | Word at rd_index, valid in the same cycle |
| rd_present | input | 1 | Low when the source of that word is absent |

## Verification
A wrong offset in the block shows up at the first data byte of the next read: the byte no longer matches the word and lane that the host selected. The error persists for every byte after that, because the offset only ever increments. A wrong transfer state shows up within one SCL period. It appears as an ACK missing where one is due, or as SDA held low in the host's ACK slot. Edge misplacement is caught every clock by watching SDA while SCL is high.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } xfer_state_e;

    // one synchronized sample of the two bus lines
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_pair_t;

    function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] lane);
        logic [BYTE_W-1:0] b;
        case (lane)
            2'd0:    b = w[7:0];
            2'd1:    b = w[15:8];
            2'd2:    b = w[23:16];
            default: b = w[31:24];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int       WIDTH   = 2,
    parameter int       STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_map.sv
module i2ct_map
    import i2ct_pkg::*;
#(
    parameter logic [OFF_W-1:0]  BASE      = 16'h0100,
    parameter int                NWORDS    = 30,
    parameter int                LINK_IDX  = 25,
    parameter int                LINK_BITS = 8,
    parameter logic [WORD_W-1:0] MISS_WORD = 32'hDEAD_BEEF,
    localparam int               IDX_W     = $clog2(NWORDS)
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              rd_present,
    output logic [IDX_W-1:0]  rd_index,
    output logic [BYTE_W-1:0] tx_byte
);
    localparam logic [OFF_W:0] SPAN = (OFF_W+1)'(4 * NWORDS);

    logic [OFF_W-1:0]  rel;
    logic              hit;
    logic [WORD_W-1:0] shaped;

    // offsets below BASE wrap to large values and fall outside SPAN
    assign rel      = offset - BASE;
    assign hit      = ({1'b0, rel} < SPAN);
    assign rd_index = hit ? rel[IDX_W+1:2] : '0;

    always_comb begin
        if (!rd_present)
            shaped = MISS_WORD;
        else if (rd_index == IDX_W'(LINK_IDX))
            shaped = {{(WORD_W-LINK_BITS){1'b0}}, rd_word[LINK_BITS-1:0]};
        else
            shaped = rd_word;
    end

    assign tx_byte = hit ? lane_of(shaped, rel[1:0]) : '0;
endmodule

// File: rtl/i2ct_slave.sv
module i2ct_slave
    import i2ct_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h5E,
    parameter logic [OFF_W-1:0]  BASE        = 16'h0100,
    parameter int                NWORDS      = 30,
    parameter int                LINK_IDX    = 25,
    parameter int                LINK_BITS   = 8,
    parameter logic [WORD_W-1:0] MISS_WORD   = 32'hDEAD_BEEF,
    parameter int                SYNC_STAGES = 2,
    localparam int               IDX_W       = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [IDX_W-1:0]  rd_index,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              rd_present
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    bus_pair_t   now_s, prev_q;
    logic        scl_rise, scl_fall, start_evt, stop_evt;

    xfer_state_e       state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-2:0] tx_sh;
    logic              rw_q;
    logic              mst_ack;
    logic [1:0]        wr_idx;
    logic [OFF_W-1:0]  offset;
    logic              sda_low;
    logic [BYTE_W-1:0] tx_byte;

    i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (now_s)
    );

    i2ct_map #(
        .BASE(BASE), .NWORDS(NWORDS), .LINK_IDX(LINK_IDX),
        .LINK_BITS(LINK_BITS), .MISS_WORD(MISS_WORD)
    ) u_map (
        .offset     (offset),
        .rd_word    (rd_word),
        .rd_present (rd_present),
        .rd_index   (rd_index),
        .tx_byte    (tx_byte)
    );

    assign scl_rise  =  now_s.scl & ~prev_q.scl;
    assign scl_fall  = ~now_s.scl &  prev_q.scl;
    assign start_evt =  now_s.scl &  prev_q.scl &  prev_q.sda & ~now_s.sda;
    assign stop_evt  =  now_s.scl &  prev_q.scl & ~prev_q.sda &  now_s.sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '{scl: 1'b1, sda: 1'b1};
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rw_q    <= 1'b0;
            mst_ack <= 1'b0;
            wr_idx  <= '0;
            offset  <= '0;
            sda_low <= 1'b0;
        end else begin
            prev_q <= now_s;
            if (start_evt) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                wr_idx  <= '0;
                sda_low <= 1'b0;
            end else if (stop_evt) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], now_s.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                                state   <= ST_ADDR_ACK;
                                sda_low <= 1'b1;
                                rw_q    <= rx_sh[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_sh   <= tx_byte[BYTE_W-2:0];
                                sda_low <= ~tx_byte[BYTE_W-1];
                                offset  <= offset + 16'd1;
                                state   <= ST_RD_BYTE;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], now_s.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            case (wr_idx)
                                2'd0:    offset[15:8] <= rx_sh;
                                2'd1:    offset[7:0]  <= rx_sh;
                                default: ;
                            endcase
                            if (wr_idx != 2'd2) wr_idx <= wr_idx + 2'd1;
                            sda_low <= 1'b1;
                            state   <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_low <= 1'b0;
                                state   <= ST_RD_ACK;
                            end else begin
                                sda_low <= ~tx_sh[BYTE_W-2];
                                tx_sh   <= {tx_sh[BYTE_W-3:0], 1'b0};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~now_s.sda;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                tx_sh   <= tx_byte[BYTE_W-2:0];
                                sda_low <= ~tx_byte[BYTE_W-1];
                                offset  <= offset + 16'd1;
                                bit_cnt <= '0;
                                state   <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe = sda_low;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
    import i2ct_pkg::*;
#(
    parameter int  NWORDS = 30,
    localparam int IDX_W  = $clog2(NWORDS)
) (
    input logic             clk,
    input logic             rst,
    input xfer_state_e      state,
    input logic             sda_oe,
    input logic             scl_fall,
    input logic             start_evt,
    input logic             stop_evt,
    input logic [IDX_W-1:0] rd_index
);
    // R9: no drive while idle
    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R9: host owns SDA in its ACK slot
    a_r9_host_ack_slot: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK) |-> !sda_oe);

    // R3: every write data byte is acknowledged
    a_r3_write_acked: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_ACK) |-> sda_oe);

    // R12: SDA moves only after an SCL fall or a bus condition
    a_r12_sda_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

    // R6: register port never addresses past the bank
    a_r6_index_in_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, rd_index} < (IDX_W+1)'(NWORDS)));
endmodule

bind i2ct_slave i2ct_checker #(.NWORDS(NWORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_index  (rd_index)
);

// File: tb/sim_i2ct_slave.sv
module sim_i2ct_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int NW         = 30;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [4:0]  rd_index;
    logic [31:0] rd_word;
    logic        rd_present;
    logic        sda_line;

    logic [31:0] regs [NW];
    logic        present [NW];

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int proto_err = 0;
    int model_off = 0;
    bit done = 0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line   = m_sda & ~sda_oe;
    assign rd_word    = regs[rd_index];
    assign rd_present = present[rd_index];

    i2ct_slave u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .rd_index(rd_index), .rd_word(rd_word),
        .rd_present(rd_present)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock protocol comparison: R12, SDA never moves while SCL stays high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && prev_scl && m_scl && (sda_oe !== prev_oe)) proto_err++;
        prev_scl <= m_scl;
        prev_oe  <= sda_oe;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= LIMIT && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input int off);
        int idx;
        logic [31:0] w;
        if (off < 'h100 || off > 'h177) return 8'h00;
        idx = (off - 'h100) / 4;
        if (!present[idx])   w = 32'hDEADBEEF;
        else if (idx == 25)  w = regs[idx] & 32'h0000_00FF;
        else                 w = regs[idx];
        return 8'(w >> (8 * (off % 4)));
    endfunction

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wait_h(HALF);
        m_scl = 1'b1; wait_h(HALF);
        m_sda = 1'b0; wait_h(HALF);
        m_scl = 1'b0; wait_h(2);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wait_h(HALF);
        m_scl = 1'b1; wait_h(HALF);
        m_sda = 1'b1; wait_h(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_h(HALF);
            m_scl = 1'b1; wait_h(HALF);
            m_scl = 1'b0; wait_h(2);
        end
        m_sda = 1'b1; wait_h(HALF);
        m_scl = 1'b1; wait_h(HALF/2);
        ack = !sda_line; wait_h(HALF/2);
        m_scl = 1'b0; wait_h(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_h(HALF);
            m_scl = 1'b1; wait_h(HALF/2);
            b[i] = sda_line; wait_h(HALF/2);
            m_scl = 1'b0; wait_h(2);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wait_h(HALF);
        m_scl = 1'b1; wait_h(HALF/2);
        if (!give_ack) chk(sda_oe == 1'b0, "R9 host ack slot released", int'(sda_oe), 0);
        wait_h(HALF/2);
        m_scl = 1'b0; wait_h(2);
        m_sda = 1'b1; wait_h(HALF);
    endtask

    task automatic set_off(input int off, input int extra, input bit do_stop);
        bit a;
        i2c_start();
        send_byte(8'hBC, a); chk(a, "R1 address ack (write)", int'(a), 1);
        send_byte(8'(off >> 8), a); chk(a, "R2 offset high ack", int'(a), 1);
        send_byte(8'(off), a); chk(a, "R2 offset low ack", int'(a), 1);
        for (int k = 0; k < extra; k++) begin
            send_byte(8'h5A ^ 8'(k), a); chk(a, "R3 extra data ack", int'(a), 1);
        end
        if (do_stop) i2c_stop();
        model_off = off;
    endtask

    task automatic rd_bytes(input int n, input string req);
        bit a;
        logic [7:0] got, want;
        i2c_start();
        send_byte(8'hBD, a); chk(a, "R1 address ack (read)", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(exp_byte(model_off));
            model_off = (model_off + 1) & 'hFFFF;
        end
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, got);
            want = exp_q.pop_front();
            chk(got == want, req, int'(got), int'(want));
        end
        chk(sda_oe == 1'b0, "R9 released after NACK", int'(sda_oe), 0);
        i2c_stop();
    endtask

    initial begin
        bit a;
        for (int i = 0; i < NW; i++) begin
            regs[i]    = {8'(i + 1), 8'(i * 3 + 7), 8'(8'hA0 ^ 8'(i)), 8'(8'h40 + i)};
            present[i] = 1'b1;
        end
        regs[25]   = 32'hCAFE_12A5;
        present[7] = 1'b0;

        wait_h(5);
        rst = 1'b0;
        wait_h(5);

        // R10 reset state
        chk(sda_oe == 1'b0, "R10 SDA released after reset", int'(sda_oe), 0);
        rd_bytes(2, "R10 offset zero reads 0x00");

        // R1 mismatched address then ignored byte
        i2c_start();
        send_byte(8'hA0, a); chk(!a, "R1 wrong address NACK", int'(a), 0);
        send_byte(8'h01, a); chk(!a, "R1 ignored until START", int'(a), 0);
        i2c_stop();
        rd_bytes(1, "R1 offset untouched by foreign address");

        // R2/R4 basic word, LSB first
        set_off('h100, 0, 1);
        rd_bytes(4, "R4 word 0 LSB first");

        // R4 mid-word lane
        set_off('h102, 0, 1);
        rd_bytes(2, "R4 upper lanes");

        // R5 crossing words
        set_off('h10C, 0, 1);
        rd_bytes(8, "R5 auto increment across words");

        // R7 link-status mask
        set_off('h164, 0, 1);
        rd_bytes(4, "R7 link word upper bits zero");

        // R8 absent source
        set_off('h11C, 0, 1);
        rd_bytes(4, "R8 absent marker");

        // R6 end of window
        set_off('h174, 0, 1);
        rd_bytes(8, "R6 past window reads zero");

        // R6 below window into window
        set_off('h0FE, 0, 1);
        rd_bytes(4, "R6 below window then R5 into window");

        // R3 extra write bytes discarded
        set_off('h110, 2, 1);
        rd_bytes(4, "R3 offset kept after extra bytes");

        // R11 repeated start keeps offset
        set_off('h140, 0, 0);
        rd_bytes(5, "R11 repeated START read");

        // R5 continuation across separate reads
        rd_bytes(3, "R5 offset carried between reads");

        chk(proto_err == 0, "R12 SDA stable while SCL high", proto_err, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule